// File: doc/BRIEF.md
# Dual-Tone Alert Guard-Time Qualifier

This block takes the raw "both alert tones present" flag produced by an upstream tone detector and turns it into a steering output that can be trusted. The output rises only once the raw flag has stayed high, without a break, for a programmable tone-present guard time. Once it is up, it rides through short losses of detection and falls only after the raw flag has stayed low for a programmable tone-absent guard time. Both guard times are counted digitally in whole milliseconds. The millisecond tick is derived from the system clock by a prescaler.

Two overrides force the steering output low. A detector-disable input silences the output while qualification keeps running underneath. A power-down input also blanks the registered copy of the raw flag and clears all guard timing. A configuration-error flag reports any setting where the present guard time is not longer than the absent guard time.

Top module: `tone_guard_qual`

## Requirements
- R1: `steer_out` rises only after the raw flag has been high, as seen through its input register, for `present_ms` consecutive millisecond ticks.
- R2: If the raw flag drops before the present guard time has elapsed, the elapsed present time is discarded, and a later rise must wait a full `present_ms` again.
- R3: While `steer_out` is high, a loss of the raw flag that is shorter than `absent_ms` ticks leaves `steer_out` high.
- R4: While `steer_out` is high, a loss of the raw flag that lasts `absent_ms` ticks drives `steer_out` low.
- R5: `cfg_err` is 1, one cycle after the configuration is applied, whenever `present_ms` <= `absent_ms`. Otherwise it is 0.
- R6: While `det_disable` is 1, `steer_out` is 0 and qualification continues. If the qualified state still holds when `det_disable` returns to 0, `steer_out` is 1 on the next cycle.
- R7: While `pwr_down` is 1, `steer_out` and `early_out` are 0 and all guard timing is cleared. After release, a full present guard time is needed again.
- R8: One millisecond tick occurs every `CLK_PER_MS` clock cycles. The guard times are unsigned 8-bit millisecond counts in the range 0 to 255.
- R9: All outputs are registered. `early_out` follows `early_in` (gated by `pwr_down`) with one cycle of latency. `steer_out` changes only at a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| early_in | input | 1 | Raw dual-tone detection flag from the tone detector |
| present_ms | input | 8 | Tone-present guard time in milliseconds |
| absent_ms | input | 8 | Tone-absent guard time in milliseconds |
| det_disable | input | 1 | Holds the steering output low while qualification continues |
| pwr_down | input | 1 | Power-down; forces the outputs low and clears the timers |
| steer_out | output | 1 | Guard-time-qualified steering output |
| early_out | output | 1 | Registered raw flag, forced low in power-down |
| cfg_err | output | 1 | Present guard time not greater than the absent guard time |

## Verification
The bench builds the block with `CLK_PER_MS` = 4, so that one millisecond lasts four clock cycles. At that scale a realistic 20 ms present guard and 16 ms absent guard run in about a hundred cycles. Every tick phase, every dropout length around the absent limit, and the disable and power-down overrides in the middle of a qualification can then be driven in a short run. A behavioural model tracks the elapsed millisecond counts with integers and is compared against all three outputs on every clock. Directed windows then check the rise and fall bounds against the guard times.

// File: rtl/tgq_pkg.sv
// Package: shared definitions for the dual-tone guard-time qualifier.
// Assumes: a single clock domain. Guard times are whole milliseconds.
package tgq_pkg;
    localparam int unsigned GUARD_W = 8;

    typedef logic [GUARD_W-1:0] guard_t;

    // Qualification state: waiting for a valid tone, or holding steering high.
    typedef enum logic {
        ST_WAIT = 1'b0,
        ST_HELD = 1'b1
    } tgq_state_e;
endpackage

// File: rtl/tgq_ms_tick.sv
// Module: millisecond tick prescaler.
// Emits a one-cycle tick every CLK_PER_MS clocks. Free-running after reset.
// Assumes: CLK_PER_MS >= 1.
module tgq_ms_tick #(
    parameter int unsigned CLK_PER_MS = 125000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_PER_MS - 1);

    logic [CW-1:0] pre_cnt;

    assign tick = (pre_cnt == LAST);

    // Advance the prescaler and wrap on the tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    pre_cnt <= '0;
        else if (tick) pre_cnt <= '0;
        else           pre_cnt <= pre_cnt + 1'b1;
    end
endmodule

// File: rtl/tgq_guard_timer.sv
// Module: saturating millisecond guard timer.
// Counts ticks while not cleared. 'done' reports that the elapsed count
// has reached 'limit'. A limit of zero is reached at once.
// Assumes: clr has priority over tick.
module tgq_guard_timer
    import tgq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   clr,
    input  logic   tick,
    input  guard_t limit,
    output guard_t elapsed,
    output logic   done
);
    localparam guard_t SAT = '1;

    assign done = (elapsed >= limit);

    // Clear, or count ticks up to saturation.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)            elapsed <= '0;
        else if (tick && elapsed != SAT) elapsed <= elapsed + 1'b1;
    end
endmodule

// File: rtl/tone_guard_qual.sv
// Module: dual-tone alert guard-time qualifier (top).
// Registers the raw detection flag. Qualifies it with a present guard timer
// and an absent guard timer, and drives a registered steering output. The
// disable input masks only the output. Power-down also clears the state,
// the timers and the registered raw flag.
// Assumes: a synchronous active-low reset, and quasi-static configuration.
module tone_guard_qual
    import tgq_pkg::*;
#(
    parameter int unsigned CLK_PER_MS = 125000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       early_in,
    input  logic [7:0] present_ms,
    input  logic [7:0] absent_ms,
    input  logic       det_disable,
    input  logic       pwr_down,
    output logic       steer_out,
    output logic       early_out,
    output logic       cfg_err
);
    tgq_state_e state, state_nx;
    logic       early_q;
    logic       tick;
    logic       pres_done, abs_done;
    guard_t     pres_cnt, abs_cnt;
    logic       active;

    assign active = (state == ST_HELD);

    tgq_ms_tick #(.CLK_PER_MS(CLK_PER_MS)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    tgq_guard_timer u_present (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!early_q || active || pwr_down),
        .tick    (tick),
        .limit   (present_ms),
        .elapsed (pres_cnt),
        .done    (pres_done)
    );

    tgq_guard_timer u_absent (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (early_q || !active || pwr_down),
        .tick    (tick),
        .limit   (absent_ms),
        .elapsed (abs_cnt),
        .done    (abs_done)
    );

    // Next-state decision from the registered flag and the guard timers.
    always_comb begin
        state_nx = state;
        if (pwr_down)
            state_nx = ST_WAIT;
        else if (state == ST_WAIT && early_q && pres_done)
            state_nx = ST_HELD;
        else if (state == ST_HELD && !early_q && abs_done)
            state_nx = ST_WAIT;
    end

    // Register the state, the gated raw flag, the output and the config check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_WAIT;
            early_q   <= 1'b0;
            steer_out <= 1'b0;
            cfg_err   <= 1'b0;
        end else begin
            state     <= state_nx;
            early_q   <= early_in && !pwr_down;
            steer_out <= (state_nx == ST_HELD) && !det_disable;
            cfg_err   <= (present_ms <= absent_ms);
        end
    end

    assign early_out = early_q;
endmodule

// File: rtl/tgq_checker.sv
// Module: assertion checker for tone_guard_qual, attached by bind.
// Assumes: it sees the internal registered flag, the state and the present count.
module tgq_checker #(
    parameter int unsigned CLK_PER_MS = 125000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       early_q,
    input logic       active,
    input logic       tick,
    input logic [7:0] pres_cnt,
    input logic       pwr_down,
    input logic       det_disable,
    input logic       steer_out,
    input logic       early_out
);
    // R1: entering the held state requires the raw flag high just before.
    p_rise_needs_tone_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(early_q));

    // R2: a low raw flag discards the elapsed present time.
    p_present_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !early_q |=> (pres_cnt == 8'd0));

    // R4: leaving the held state, other than by power-down, needs the flag low.
    p_fall_needs_absence_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(active) && !$past(pwr_down)) |-> !$past(early_q));

    // R6: disable forces the steering output low on the next cycle.
    p_disable_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        det_disable |=> !steer_out);

    // R7: power-down forces both outputs low on the next cycle.
    p_pwdn_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> (!steer_out && !early_out));

    // R8: a tick never repeats on the following cycle when a millisecond is longer than one clock.
    p_tick_spacing_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && CLK_PER_MS > 1) |=> !tick);
endmodule

bind tone_guard_qual tgq_checker #(.CLK_PER_MS(CLK_PER_MS)) u_tgq_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .early_q     (early_q),
    .active      (active),
    .tick        (tick),
    .pres_cnt    (pres_cnt),
    .pwr_down    (pwr_down),
    .det_disable (det_disable),
    .steer_out   (steer_out),
    .early_out   (early_out)
);

// File: tb/tone_guard_qual_bench.sv
// Bench: behavioural model compared on every clock, plus directed windows.
module tone_guard_qual_bench;
    localparam int unsigned N = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       early_in = 1'b0;
    logic [7:0] present_ms = 8'd20;
    logic [7:0] absent_ms = 8'd16;
    logic       det_disable = 1'b0;
    logic       pwr_down = 1'b0;
    logic       steer_out, early_out, cfg_err;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tone_guard_qual #(.CLK_PER_MS(N)) u_tone_guard_qual (
        .clk(clk), .rst_n(rst_n), .early_in(early_in),
        .present_ms(present_ms), .absent_ms(absent_ms),
        .det_disable(det_disable), .pwr_down(pwr_down),
        .steer_out(steer_out), .early_out(early_out), .cfg_err(cfg_err)
    );

    // Behavioural model state: elapsed ms while tone present/absent, and clock phase.
    int  m_phase = 0;
    int  m_on_ms = 0;
    int  m_off_ms = 0;
    bit  m_valid = 0;
    bit  m_early = 0;
    bit  m_steer = 0;
    bit  m_cfg = 0;

    always @(posedge clk) begin
        bit ms_edge;
        bit valid_nx;
        cyc++;
        if (!rst_n) begin
            m_phase = 0; m_on_ms = 0; m_off_ms = 0; m_valid = 0;
            m_early = 0; m_steer = 0; m_cfg = 0;
        end else begin
            ms_edge = (m_phase == N - 1);
            if (pwr_down)                                   valid_nx = 0;
            else if (!m_valid)                              valid_nx = m_early && (m_on_ms >= present_ms);
            else                                            valid_nx = m_early || (m_off_ms < absent_ms);
            if (!m_early || m_valid || pwr_down) m_on_ms = 0;
            else if (ms_edge && m_on_ms < 255) m_on_ms++;
            if (m_early || !m_valid || pwr_down) m_off_ms = 0;
            else if (ms_edge && m_off_ms < 255) m_off_ms++;
            m_phase = ms_edge ? 0 : m_phase + 1;
            m_valid = valid_nx;
            m_steer = valid_nx && !det_disable;
            m_early = early_in && !pwr_down;
            m_cfg   = (present_ms <= absent_ms);
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Compare the model with the design on every falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R8 steer vs model", steer_out, m_steer);
            check("R9 early_out vs model", early_out, m_early);
            check("R5 cfg_err vs model", cfg_err, m_cfg);
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int rise_at;
        wait_cyc(3);
        check("R9 reset steer", steer_out, 1'b0);
        check("R9 reset early_out", early_out, 1'b0);
        rst_n = 1'b1;
        wait_cyc(2);
        check("R5 cfg ok 20/16", cfg_err, 1'b0);

        // R1: 19 ms of tone is not enough, 22 ms is.
        early_in = 1'b1;
        wait_cyc(19 * N);
        check("R1 before present time", steer_out, 1'b0);
        wait_cyc(3 * N);
        check("R1 after present time", steer_out, 1'b1);

        // R3: a 10 ms dropout is masked.
        early_in = 1'b0;
        wait_cyc(10 * N);
        check("R3 dropout masked", steer_out, 1'b1);
        early_in = 1'b1;
        wait_cyc(2);
        check("R3 still held", steer_out, 1'b1);

        // R4: a 20 ms absence drops the output.
        early_in = 1'b0;
        wait_cyc(15 * N);
        check("R4 before absent time", steer_out, 1'b1);
        wait_cyc(5 * N);
        check("R4 after absent time", steer_out, 1'b0);

        // R2: 12 ms tone, a one-cycle gap, then 12 ms more: still not qualified.
        early_in = 1'b1;
        wait_cyc(12 * N);
        early_in = 1'b0;
        wait_cyc(1);
        early_in = 1'b1;
        wait_cyc(12 * N);
        check("R2 gap restarts present time", steer_out, 1'b0);
        wait_cyc(10 * N);
        check("R2 qualifies after full time", steer_out, 1'b1);

        // R6: disable masks the output and releases back to high.
        det_disable = 1'b1;
        wait_cyc(2);
        check("R6 disabled low", steer_out, 1'b0);
        check("R6 early_out unaffected", early_out, 1'b1);
        det_disable = 1'b0;
        wait_cyc(1);
        check("R6 release restores", steer_out, 1'b1);

        // R7: power-down forces both low and clears timing.
        pwr_down = 1'b1;
        wait_cyc(2);
        check("R7 steer low in power-down", steer_out, 1'b0);
        check("R7 early_out low in power-down", early_out, 1'b0);
        pwr_down = 1'b0;
        wait_cyc(10 * N);
        check("R7 requalify needed", steer_out, 1'b0);
        early_in = 1'b0;
        wait_cyc(30 * N);

        // R5: an inverted configuration is flagged.
        present_ms = 8'd10; absent_ms = 8'd12;
        wait_cyc(2);
        check("R5 cfg error 10/12", cfg_err, 1'b1);
        present_ms = 8'd12;
        wait_cyc(2);
        check("R5 cfg error equal", cfg_err, 1'b1);

        // R8: rise latency for a 5 ms present time lies within one tick phase.
        present_ms = 8'd5; absent_ms = 8'd2;
        wait_cyc(4);
        early_in = 1'b1;
        rise_at = -1;
        for (int i = 1; i <= 40; i++) begin
            @(negedge clk);
            if (steer_out && rise_at < 0) rise_at = i;
        end
        checks++;
        if (rise_at < 5 * N - 1 || rise_at > 5 * N + 3) begin
            errors++;
            $display("FAIL R8 rise latency: actual %0d expected %0d..%0d", rise_at, 5 * N - 1, 5 * N + 3);
        end
        early_in = 1'b0;
        wait_cyc(4 * N);
        check("R4 short absent time", steer_out, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: an overrun counts as a failed check.
    initial begin
        wait_cyc(150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule